// File: doc/BRIEF.md
# Receive Character Buffer with Line Status

This block is the receive-side character store for one serial channel. A receiver shifter hands it each completed character together with three error tags: parity, framing and break. The block keeps up to sixteen such characters in arrival order. Each character carries its tags through the buffer, so the status the processor sees always describes the character it is about to read.

The processor reads the oldest character through a data-read strobe and reads an 8-bit line status word through a separate strobe. The status word combines several things: data-ready, a sticky overrun flag, the head character's tags, two transmit-side empty indications passed in from the transmitter, and a summary bit that reports an error anywhere in the buffer. A data-available interrupt asserts while the stored count is at or above a level chosen by a two-bit select. When the buffer is disabled, the block behaves as a single-character holding register.

Top module: `rx_line_fifo`

## Requirements
- R1: With `fifo_en` high, the buffer accepts 16 characters. A 17th character written while it holds 16 is an overrun. Characters are read back in arrival order on `rd_data`, which shows the head character whenever the buffer is not empty.
- R2: With `fifo_en` low, capacity is one character. A character that arrives while one is held is an overrun.
- R3: Overrun is judged on the count at the start of the cycle, even if a read happens in the same cycle. The arriving character is discarded, the stored characters and count are unchanged, and `lsr[1]` is set on the next cycle. If an overrun and a status read fall in the same cycle, the set wins.
- R4: `lsr[0]` is 1 exactly when at least one character is stored. A `rd_data_stb` pulse removes the head character if there is one, and does nothing when the buffer is empty.
- R5: `lsr[2]` (parity), `lsr[3]` (framing) and `lsr[4]` (break) show the tags of the head character. They read 0 when the buffer is empty. After a status read they read 0 until the head character is removed.
- R6: A status read clears `lsr[1]` on the next cycle, unless a new overrun occurs in that same cycle.
- R7: With `fifo_en` high, `lsr[7]` is 1 from the cycle after a character with any tag is accepted. It stays 1 until no stored character carries a tag and a status read has taken place, either in the cycle that removes the last tagged character or later.
- R8: With `fifo_en` low, `lsr[7]` reads 0.
- R9: `data_irq` is 1 while the count is at or above a level. With `fifo_en` high, `trig_sel` sets the level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. With `fifo_en` low, the level is 1.
- R10: `lsr[5]` follows `thr_empty` and `lsr[6]` follows `tx_empty` without delay.
- R11: Reset empties the buffer and clears the overrun, hidden-tag and error-summary state. Right after reset, `lsr` equals {1'b0, tx_empty, thr_empty, 5'b0} and `data_irq` is 0. Character storage itself is not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1: 16-deep buffer; 0: single-character mode |
| trig_sel | input | 2 | Interrupt level select |
| wr_stb | input | 1 | Character-complete strobe from the receiver |
| wr_data | input | 8 | Received character |
| wr_perr | input | 1 | Parity error tag of the character |
| wr_ferr | input | 1 | Framing error tag of the character |
| wr_brk | input | 1 | Break tag of the character |
| rd_data_stb | input | 1 | Processor read of the data register |
| rd_lsr_stb | input | 1 | Processor read of the line status register |
| thr_empty | input | 1 | Transmit holding empty, from the transmitter |
| tx_empty | input | 1 | Transmitter fully empty, from the transmitter |
| rd_data | output | 8 | Head character |
| lsr | output | 8 | Line status word |
| data_irq | output | 1 | Data-available interrupt |

## Verification
The assertions assume that each strobe is a single-cycle pulse decided by the caller. They also assume that `fifo_en` may change while characters are stored, with capacity then judged on the new setting. The stimulus keeps to this in two ways. It drives every input only on the falling clock edge, and it allows random toggling of `fifo_en` and `trig_sel` mid-stream, so that any value the assertions may see is one a real host could produce. Directed phases push the buffer to exactly full and then one beyond, and they put overrun and a status read in the same cycle.

// File: rtl/rx_line_fifo.sv
module rx_line_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [1:0]    trig_sel,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_perr,
  input  logic          wr_ferr,
  input  logic          wr_brk,
  input  logic          rd_data_stb,
  input  logic          rd_lsr_stb,
  input  logic          thr_empty,
  input  logic          tx_empty,
  output logic [DW-1:0] rd_data,
  output logic [7:0]    lsr,
  output logic          data_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int TW = DW + 3;

  logic [TW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count, err_cnt, cap, level;
  logic          oe, hide, err_hold;

  wire [TW-1:0] head   = mem[rptr];
  wire          empty  = (count == '0);
  assign        cap    = fifo_en ? CW'(DEPTH) : CW'(1);
  wire          full   = (count >= cap);
  wire          pop    = rd_data_stb && !empty;
  wire          push   = wr_stb && !full;
  wire          ovr    = wr_stb && full;
  wire          in_err = wr_perr | wr_ferr | wr_brk;
  wire          h_err  = |head[TW-1:DW];
  wire [CW-1:0] err_nxt = err_cnt + CW'(push && in_err) - CW'(pop && h_err);
  wire          show   = !empty && !hide;

  always_comb begin
    if (!fifo_en) level = CW'(1);
    else case (trig_sel)
      2'b00:   level = CW'(1);
      2'b01:   level = CW'(4);
      2'b10:   level = CW'(8);
      default: level = CW'(14);
    endcase
  end

  always_ff @(posedge clk)
    if (push) mem[wptr] <= {wr_brk, wr_ferr, wr_perr, wr_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; count <= '0; err_cnt <= '0;
      oe <= 1'b0; hide <= 1'b0; err_hold <= 1'b0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      count    <= count + CW'(push) - CW'(pop);
      err_cnt  <= err_nxt;
      oe       <= ovr ? 1'b1 : (rd_lsr_stb ? 1'b0 : oe);
      hide     <= pop ? 1'b0 : ((rd_lsr_stb && !empty) ? 1'b1 : hide);
      err_hold <= (err_nxt != '0) ? 1'b1 : (rd_lsr_stb ? 1'b0 : err_hold);
    end
  end

  assign rd_data  = head[DW-1:0];
  assign data_irq = (count >= level);
  assign lsr = {fifo_en & err_hold, tx_empty, thr_empty,
                show & head[DW+2], show & head[DW+1], show & head[DW],
                oe, !empty};

  a_r1_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r3_ovr_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> lsr[1]);
  a_r3_ovr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !rd_data_stb) |=> $stable(count));
  a_r6_lsr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr_stb && !wr_stb) |=> !lsr[1]);
  a_r4_last_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_stb && count == CW'(1) && !wr_stb) |=> !lsr[0]);
  a_r7_err_subset: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= count);
endmodule

// File: tb/sim_rx_line_fifo.sv
`timescale 1ns/1ps
module sim_rx_line_fifo;
  logic clk = 0, rst_n = 0;
  logic fifo_en = 1, wr_stb = 0, wr_perr = 0, wr_ferr = 0, wr_brk = 0;
  logic rd_data_stb = 0, rd_lsr_stb = 0, thr_empty = 1, tx_empty = 1;
  logic [1:0] trig_sel = 2'b11;
  logic [7:0] wr_data = 0, rd_data, lsr;
  logic data_irq;

  rx_line_fifo u0 (.clk, .rst_n, .fifo_en, .trig_sel, .wr_stb, .wr_data,
    .wr_perr, .wr_ferr, .wr_brk, .rd_data_stb, .rd_lsr_stb, .thr_empty,
    .tx_empty, .rd_data, .lsr, .data_irq);

  always #10 clk = ~clk;

  logic [10:0] q[$];
  bit m_oe, m_hide, m_hold;
  int vectors = 0, errors = 0;
  bit done = 0;

  function automatic int lvl();
    if (!fifo_en) return 1;
    case (trig_sel)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic model_reset();
    q.delete(); m_oe = 0; m_hide = 0; m_hold = 0;
  endtask

  task automatic model_upd();
    int cap = fifo_en ? 16 : 1;
    bit full = (q.size() >= cap);
    bit pop  = rd_data_stb && q.size() > 0;
    int ne = 0;
    bit had = (q.size() > 0);
    if (pop) void'(q.pop_front());
    if (wr_stb && !full) q.push_back({wr_brk, wr_ferr, wr_perr, wr_data});
    if (wr_stb && full) m_oe = 1;
    else if (rd_lsr_stb) m_oe = 0;
    if (pop) m_hide = 0;
    else if (rd_lsr_stb && had) m_hide = 1;
    foreach (q[i]) if (q[i][10:8] != 0) ne++;
    if (ne > 0) m_hold = 1;
    else if (rd_lsr_stb) m_hold = 0;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic compare();
    bit ne = q.size() > 0;
    bit show = ne && !m_hide;
    vectors++;
    chk("R4 data ready",      {7'd0, lsr[0]}, {7'd0, ne});
    chk("R3/R6 overrun",      {7'd0, lsr[1]}, {7'd0, m_oe});
    chk("R5 head tags",       {5'd0, lsr[4:2]}, {5'd0, show ? q[0][10:8] : 3'b000});
    chk("R10 transmit flags", {6'd0, lsr[6:5]}, {6'd0, tx_empty, thr_empty});
    chk("R7/R8 error summary",{7'd0, lsr[7]}, {7'd0, fifo_en && m_hold});
    chk("R9 interrupt",       {7'd0, data_irq}, {7'd0, q.size() >= lvl()});
    if (ne) chk("R1 head data", rd_data, q[0][7:0]);
  endtask

  task automatic cyc();
    @(posedge clk);
    if (rst_n) model_upd(); else model_reset();
    @(negedge clk);
    compare();
  endtask

  task automatic step(bit w, byte d, bit [2:0] tg, bit rd, bit rl);
    wr_stb = w; wr_data = d; {wr_brk, wr_ferr, wr_perr} = tg;
    rd_data_stb = rd; rd_lsr_stb = rl;
    cyc();
    wr_stb = 0; rd_data_stb = 0; rd_lsr_stb = 0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (3) cyc();
    rst_n = 1;
    chk("R11 reset lsr", lsr, 8'h60);
    chk("R11 reset irq", {7'd0, data_irq}, 8'd0);
    // R1, R9: fill to 16 at level 14, tags on some entries (R5, R7)
    for (int i = 0; i < 16; i++) step(1, 8'h30 + i, (i % 5 == 2) ? 3'(i % 7) : 3'b000, 0, 0);
    // R3: overrun when full, set wins against a simultaneous status read
    step(1, 8'hEE, 3'b111, 0, 1);
    step(0, 0, 0, 0, 1);           // R6 clear
    step(1, 8'hEF, 0, 1, 0);       // R3: full at cycle start, read same cycle
    // R10 pass-through
    thr_empty = 0; tx_empty = 0; step(0, 0, 0, 0, 0);
    thr_empty = 1; step(0, 0, 0, 0, 0);
    // drain with status reads interleaved (R4, R5, R7)
    for (int i = 0; i < 18; i++) step(0, 0, 0, 1, i % 2);
    step(0, 0, 0, 0, 1);           // R7 clear after last tagged gone
    step(0, 0, 0, 1, 0);           // R4 read on empty has no effect
    // R9 other levels
    trig_sel = 2'b01; for (int i = 0; i < 5; i++) step(1, 8'h10 + i, 0, 0, 0);
    trig_sel = 2'b10; for (int i = 0; i < 4; i++) step(1, 8'h20 + i, 3'b010, 0, 0);
    trig_sel = 2'b00; for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 1);
    // R2, R8: single-character mode
    fifo_en = 0;
    step(1, 8'hA1, 3'b001, 0, 0);
    step(1, 8'hA2, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 0);
    fifo_en = 1;
    // mixed random traffic
    for (int i = 0; i < 6000; i++) begin
      int r = $urandom % 100;
      if (r < 2) fifo_en = ~fifo_en;
      if (r > 96) trig_sel = 2'($urandom);
      thr_empty = 1'($urandom); tx_empty = 1'($urandom);
      step(($urandom % 3) != 0, 8'($urandom),
           (($urandom % 4) == 0) ? 3'($urandom) : 3'b000,
           ($urandom % 3) == 0, ($urandom % 4) == 0);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule